// File: doc/BRIEF.md
# Return-to-Zero Serial Word Transmitter

This block sends one 32-bit word at a time on a three-level return-to-zero line. While the block is idle, the host writes the word into a parallel-load shift register. The host then pulses a start input. A sequencer takes its timing from a slow square-wave reference that is sampled in the system clock domain. It produces exactly one bit cell for each data bit, least significant bit first, and counts the bits with a 6-bit counter.

Each bit cell lasts four reference rising edges. For the first two, the line drives HI for a 1 or LO for a 0. For the last two, it returns to NULL. The three line states are given as two registered digital drive enables, one for HI and one for LO, for an external line driver. When the last bit cell ends, an end-of-word interrupt is set. It stays set until the host pulses start again.

Top module: `rz_word_tx`

## Requirements
- R1: After a synchronous reset, `drive_hi_o`, `drive_lo_o` and `word_done_o` are all 0.
- R2: A `load_i` pulse captures `load_data_i` only while no word is being sent. A load during a transmission leaves the word in flight unchanged.
- R3: A rising edge on `start_i` while idle sends exactly 32 bit cells. Bit 0 goes first and bit 31 goes last.
- R4: In the drive half of a bit cell, a data bit of 1 gives `drive_hi_o`=1 and `drive_lo_o`=0, and a 0 gives `drive_hi_o`=0 and `drive_lo_o`=1. In the NULL half, both outputs are 0.
- R5: A bit cell lasts four rising edges of `ref_clk_i`. The drive half covers the first two edges and the NULL half the last two.
- R6: `drive_hi_o` and `drive_lo_o` are never 1 together. Both are 0 whenever no word is being sent.
- R7: `word_done_o` goes high when the 32nd bit cell ends. It stays high, with the line at NULL, until the next `start_i` rising edge clears it.
- R8: A `start_i` rising edge during a transmission is ignored. The sequence is not restarted, and the remaining bits and the end time are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Bit-timing reference square wave, asynchronous to clk |
| load_i | input | 1 | Parallel load strobe |
| load_data_i | input | 32 | Word to be sent |
| start_i | input | 1 | Start request; its rising edge launches a word |
| drive_hi_o | output | 1 | Line driven to the positive level |
| drive_lo_o | output | 1 | Line driven to the negative level |
| word_done_o | output | 1 | End-of-word interrupt |

## Verification
The assertions assume that the reference is much slower than `clk`, so that each of its high and low phases covers several clock cycles and the synchronizer yields clean single-cycle ticks. They also assume that `start_i` is a level that the host raises and later lowers. The bench derives the reference from a divided copy of `clk` with a period of eight cycles, and holds every start and load strobe for exactly one cycle. Disturbing strobes are placed at instants that are not aligned to the line transitions, so that each check samples a stable line state.

// File: rtl/rz_tx_pkg.sv
package rz_tx_pkg;

  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_HI   = 2'd1,
    SYM_LO   = 2'd2
  } line_sym_e;

endpackage

// File: rtl/rz_ref_tick.sv
module rz_ref_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk_i,
  output logic tick_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ref_clk_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign tick_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/rz_bit_seq.sv
module rz_bit_seq #(
  parameter int WORD_W        = 32,
  parameter int TICKS_PER_BIT = 4,
  localparam int CNT_W        = $clog2(WORD_W) + 1,
  localparam int PH_W         = $clog2(TICKS_PER_BIT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic            load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic            start_i,
  output logic            running_o,
  output logic [PH_W-1:0] phase_o,
  output logic            bit_o,
  output logic            done_o
);

  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(WORD_W - 1);
  localparam logic [PH_W-1:0]  LAST_PH   = PH_W'(TICKS_PER_BIT - 1);

  logic              busy_q;
  logic              running_q;
  logic [PH_W-1:0]   phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic              done_q;
  logic              start_q;
  logic              start_edge;

  assign start_edge = start_i & ~start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      running_q <= 1'b0;
      phase_q   <= '0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      done_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      start_q <= start_i;
      if (!busy_q) begin
        if (load_i) shreg_q <= load_data_i;
        if (start_edge) begin
          busy_q    <= 1'b1;
          running_q <= 1'b0;
          phase_q   <= '0;
          bit_cnt_q <= '0;
          done_q    <= 1'b0;
        end
      end else if (tick_i) begin
        if (!running_q) begin
          running_q <= 1'b1;
          phase_q   <= '0;
        end else if (phase_q == LAST_PH) begin
          phase_q <= '0;
          shreg_q <= shreg_q >> 1;
          if (bit_cnt_q == LAST_BIT) begin
            busy_q    <= 1'b0;
            running_q <= 1'b0;
            done_q    <= 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign running_o = running_q;
  assign phase_o   = phase_q;
  assign bit_o     = shreg_q[0];
  assign done_o    = done_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt_q <= LAST_BIT);

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ($past(bit_cnt_q) == LAST_BIT && $past(tick_i)));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done_q) |-> $past(start_edge));

  // R2
  shreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick_i) |=> $stable(shreg_q));

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_edge && !tick_i) |=> ($stable(bit_cnt_q) && $stable(phase_q)));

endmodule

// File: rtl/rz_line_enc.sv
module rz_line_enc
  import rz_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int DRIVE_TICKS   = 2,
  localparam int PH_W         = $clog2(TICKS_PER_BIT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            bit_i,
  output logic            hi_o,
  output logic            lo_o
);

  localparam logic [PH_W-1:0] DRV_END = PH_W'(DRIVE_TICKS);

  line_sym_e sym;

  always_comb begin
    sym = SYM_NULL;
    if (active_i && (phase_i < DRV_END)) sym = bit_i ? SYM_HI : SYM_LO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
    end else begin
      hi_o <= (sym == SYM_HI);
      lo_o <= (sym == SYM_LO);
    end
  end

  // R6
  no_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(hi_o && lo_o));

  // R6
  idle_null_chk: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (!hi_o && !lo_o));

  // R4
  null_half_chk: assert property (@(posedge clk) disable iff (rst)
    (active_i && phase_i >= DRV_END) |=> (!hi_o && !lo_o));

  // R4
  drive_half_chk: assert property (@(posedge clk) disable iff (rst)
    (active_i && phase_i < DRV_END) |=> (hi_o == $past(bit_i) && lo_o == !$past(bit_i)));

endmodule

// File: rtl/rz_word_tx.sv
module rz_word_tx #(
  parameter int WORD_W        = 32,
  parameter int TICKS_PER_BIT = 4,
  parameter int DRIVE_TICKS   = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              start_i,
  output logic              drive_hi_o,
  output logic              drive_lo_o,
  output logic              word_done_o
);

  localparam int PH_W = $clog2(TICKS_PER_BIT);

  logic            tick;
  logic            running;
  logic [PH_W-1:0] phase;
  logic            cur_bit;

  rz_ref_tick #(.SYNC_STAGES(SYNC_STAGES)) tick_i (
    .clk(clk), .rst(rst), .ref_clk_i(ref_clk_i), .tick_o(tick)
  );

  rz_bit_seq #(.WORD_W(WORD_W), .TICKS_PER_BIT(TICKS_PER_BIT)) seq_i (
    .clk(clk), .rst(rst), .tick_i(tick),
    .load_i(load_i), .load_data_i(load_data_i), .start_i(start_i),
    .running_o(running), .phase_o(phase), .bit_o(cur_bit), .done_o(word_done_o)
  );

  rz_line_enc #(.TICKS_PER_BIT(TICKS_PER_BIT), .DRIVE_TICKS(DRIVE_TICKS)) enc_i (
    .clk(clk), .rst(rst), .active_i(running), .phase_i(phase), .bit_i(cur_bit),
    .hi_o(drive_hi_o), .lo_o(drive_lo_o)
  );

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (word_done_o && $past(word_done_o)) |-> (!drive_hi_o && !drive_lo_o));

endmodule

// File: tb/rz_word_tx_tb.sv
module rz_word_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ref_div = '0;
  logic        ref_clk;
  logic        load = 1'b0;
  logic [31:0] load_data = '0;
  logic        start = 1'b0;
  logic        hi, lo, done;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) begin
    ref_div <= ref_div + 3'd1;
    cyc     <= cyc + 1;
  end
  assign ref_clk = ref_div[2];

  rz_word_tx dut_i (
    .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .load_i(load),
    .load_data_i(load_data), .start_i(start),
    .drive_hi_o(hi), .drive_lo_o(lo), .word_done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse_load(input logic [31:0] d);
    @(negedge clk); load = 1'b1; load_data = d;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Sends exp and checks every cell; optional disturbance at cell 10.
  task automatic run_word(input logic [31:0] exp, input bit dist_start,
                          input bit dist_load, input logic [31:0] other);
    int t0;
    int guard;
    guard = 0;
    pulse_load(exp);
    pulse_start();
    check(done == 1'b0, "R7", "done cleared by start", {31'd0, done}, 32'd0);
    while (!hi && !lo && guard < 200) begin @(negedge clk); guard++; end
    check(guard < 200, "R3", "word launched", guard, 0);
    t0 = cyc;
    for (int k = 0; k < 32; k++) begin
      wait_until(t0 + 8 + 32 * k);
      check(hi == exp[k] && lo == !exp[k], "R4", $sformatf("drive half bit %0d", k),
            {30'd0, hi, lo}, {30'd0, exp[k], !exp[k]});
      check(!(hi && lo), "R6", "exclusive drive", {30'd0, hi, lo}, 32'd0);
      wait_until(t0 + 13 + 32 * k);
      if (k == 10 && dist_start) begin start = 1'b1; @(negedge clk); start = 1'b0; end
      if (k == 10 && dist_load) begin load = 1'b1; load_data = other; @(negedge clk); load = 1'b0; end
      wait_until(t0 + 24 + 32 * k);
      check(!hi && !lo, "R5", $sformatf("null half bit %0d", k), {30'd0, hi, lo}, 32'd0);
      check(done == 1'b0, "R3", "done low mid word", {31'd0, done}, 32'd0);
    end
    wait_until(t0 + 32 * 32 - 4);
    check(done == 1'b0, "R7", "done not early", {31'd0, done}, 32'd0);
    wait_until(t0 + 32 * 32 + 4);
    check(done == 1'b1, "R7", "done after 32nd cell", {31'd0, done}, 32'd1);
    check(!hi && !lo, "R7", "line null after word", {30'd0, hi, lo}, 32'd0);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    check(!hi && !lo && !done, "R1", "reset state", {29'd0, hi, lo, done}, 32'd0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(!hi && !lo && !done, "R6", "idle after reset", {29'd0, hi, lo, done}, 32'd0);
  endtask

  task automatic t_patterns;
    run_word(32'hA5C3_0F96, 1'b0, 1'b0, 32'd0);
    run_word(32'hFFFF_FFFF, 1'b0, 1'b0, 32'd0);
    run_word(32'h0000_0000, 1'b0, 1'b0, 32'd0);
    run_word(32'h8000_0001, 1'b0, 1'b0, 32'd0);
  endtask

  task automatic t_done_hold;
    repeat (300) @(negedge clk);
    check(done == 1'b1, "R7", "done held idle", {31'd0, done}, 32'd1);
    check(!hi && !lo, "R6", "null while idle", {30'd0, hi, lo}, 32'd0);
  endtask

  task automatic t_start_busy;
    run_word(32'h1234_5678, 1'b1, 1'b0, 32'd0);
    repeat (100) @(negedge clk);
    check(!hi && !lo, "R8", "no extra word", {30'd0, hi, lo}, 32'd0);
  endtask

  task automatic t_load_busy;
    run_word(32'h0F0F_3C3C, 1'b0, 1'b1, 32'hF0F0_C3C3);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_done_hold();
    t_start_busy();
    t_load_busy();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule